// File: doc/BRIEF.md
# Packed 16-bit Lane Multiplier

This unit treats each of two 64-bit operands as four independent 16-bit lanes. It multiplies every lane of the first operand by the lane in the same position of the second operand, which gives four 32-bit products. A 2-bit opcode then picks how those products form the 64-bit result. Three modes keep one 16-bit half of each product in its own lane: the low half, the high half of a signed product, or the high half of an unsigned product. The fourth mode adds adjacent signed products in pairs and returns two 32-bit lanes.

A caller raises `start_i` for one cycle with the opcode and both operands. The unit takes a request only when it is idle. After a fixed two-cycle latency it pulses `done_o` for one cycle. `result_o` then keeps that value until the next completion.

Top module: `pmul16_unit`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` is zero and `done_o` and `busy_o` are low until a request is accepted.
- R2: Opcode 2'b00: lane i of the result (bits 16i+15..16i, lane 0 in bits 15..0) holds bits 15..0 of a_i lane i times b_i lane i. This is the same value for signed and unsigned inputs.
- R3: Opcode 2'b01: lane i of the result holds bits 31..16 of the signed two's-complement product of lane i.
- R4: Opcode 2'b10: lane i of the result holds bits 31..16 of the unsigned product of lane i.
- R5: Opcode 2'b11: bits 31..0 hold the signed product of lane 0 plus the signed product of lane 1. Bits 63..32 hold the same sum for lanes 2 and 3. Each sum wraps modulo 2^32.
- R6: In opcode 2'b11 with every lane of both operands equal to 0x8000, each 32-bit half of the result is 0x80000000.
- R7: A request accepted in cycle c gives `done_o` high for exactly cycle c+2. The new result is on `result_o` in that same cycle. `busy_o` is high in cycle c+1.
- R8: `result_o` does not change in any cycle where `done_o` is low.
- R9: A `start_i` raised while `busy_o` is high is ignored. No extra `done_o` pulse follows it, and the result stays that of the accepted request.
- R10: A `start_i` raised in the cycle where `done_o` is high is accepted, and its own completion follows two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | Mode: 00 low, 01 signed high, 10 unsigned high, 11 pairwise multiply-add |
| a_i | input | 64 | First operand, four 16-bit lanes |
| b_i | input | 64 | Second operand, four 16-bit lanes |
| busy_o | output | 1 | A request is in flight; start is not taken |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result, held between completions |

## Verification
The four products are registered at the edge that closes the start cycle. The selected or summed result is registered one edge later, so `done_o` and the new `result_o` are due in the second cycle after the start cycle. `busy_o` is due in the cycle between them. The bench drives inputs on falling edges and checks `busy_o` one falling edge after the start. It checks `done_o` and the result one falling edge after that. On the next falling edge it checks that `done_o` has dropped and the result is unchanged. The tests for back-to-back and ignored starts use the same cycle counts to show which request produced each completion.

// File: rtl/pmul16_pkg.sv
package pmul16_pkg;
  typedef enum logic [1:0] {
    OP_MUL_LO   = 2'b00,
    OP_MUL_HI_S = 2'b01,
    OP_MUL_HI_U = 2'b10,
    OP_MUL_ADD  = 2'b11
  } pmul_op_e;
endpackage

// File: rtl/pmul16_lane.sv
module pmul16_lane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]   a_i,
  input  logic [LANE_W-1:0]   b_i,
  input  logic                signed_i,
  output logic [2*LANE_W-1:0] prod_o
);
  // one extra bit selects sign or zero extension; low 2W bits are exact either way
  logic signed [LANE_W:0]     a_x, b_x;
  logic signed [2*LANE_W+1:0] full;

  assign a_x    = {signed_i & a_i[LANE_W-1], a_i};
  assign b_x    = {signed_i & b_i[LANE_W-1], b_i};
  assign full   = a_x * b_x;
  assign prod_o = full[2*LANE_W-1:0];
endmodule

// File: rtl/pmul16_combine.sv
module pmul16_combine
  import pmul16_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [LANES*PROD_W-1:0] prod_i,
  input  pmul_op_e                op_i,
  output logic [DATA_W-1:0]       res_o
);
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] pair_res;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    logic [PROD_W-1:0] p;
    assign p = prod_i[i*PROD_W +: PROD_W];
    assign half_res[i*LANE_W +: LANE_W] =
      (op_i == OP_MUL_LO) ? p[LANE_W-1:0] : p[PROD_W-1:LANE_W];
  end

  for (genvar j = 0; j < LANES/2; j++) begin : g_pair
    // wrapping sum of two signed products
    assign pair_res[j*PROD_W +: PROD_W] =
      prod_i[(2*j)*PROD_W +: PROD_W] + prod_i[(2*j+1)*PROD_W +: PROD_W];
  end

  assign res_o = (op_i == OP_MUL_ADD) ? pair_res : half_res;
endmodule

// File: rtl/pmul16_unit.sv
module pmul16_unit
  import pmul16_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  pmul_op_e                op_in, op_q;
  logic                    accept, use_signed;
  logic                    s1_vld_q, done_q;
  logic [LANES*PROD_W-1:0] prod_d, prod_q;
  logic [DATA_W-1:0]       res_d, res_q;

  assign op_in      = pmul_op_e'(op_i);
  assign accept     = start_i & ~s1_vld_q;
  assign use_signed = (op_in != OP_MUL_HI_U);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul16_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i     (a_i[i*LANE_W +: LANE_W]),
      .b_i     (b_i[i*LANE_W +: LANE_W]),
      .signed_i(use_signed),
      .prod_o  (prod_d[i*PROD_W +: PROD_W])
    );
  end

  // stage 1: products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      prod_q   <= '0;
      op_q     <= OP_MUL_LO;
    end else begin
      s1_vld_q <= accept;
      if (accept) begin
        prod_q <= prod_d;
        op_q   <= op_in;
      end
    end
  end

  pmul16_combine #(.LANES(LANES), .LANE_W(LANE_W)) u_combine (
    .prod_i(prod_q),
    .op_i  (op_q),
    .res_o (res_d)
  );

  // stage 2: result and completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= s1_vld_q;
      if (s1_vld_q) res_q <= res_d;
    end
  end

  assign busy_o   = s1_vld_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o ##1 done_o); // R7
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
  AST_BUSY_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R9
endmodule

// File: tb/pmul16_unit_tb.sv
module pmul16_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_vec = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pmul16_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // {op[1:0], a[63:0], b[63:0]}
  localparam logic [129:0] VEC [12] = '{
    {2'b00, 64'h0003_0002_0001_0000, 64'h0007_0005_0003_0009},
    {2'b00, 64'hFFFF_8000_1234_7FFF, 64'hFFFF_8000_5678_7FFF},
    {2'b01, 64'hFFFF_8000_1234_7FFF, 64'hFFFF_8000_5678_7FFF},
    {2'b01, 64'h8000_FFFF_0100_C000, 64'h7FFF_0002_0100_4000},
    {2'b10, 64'hFFFF_8000_1234_7FFF, 64'hFFFF_8000_5678_7FFF},
    {2'b10, 64'h8000_FFFF_0100_C000, 64'h7FFF_0002_0100_4000},
    {2'b11, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005},
    {2'b11, 64'hFFFF_0002_8000_7FFF, 64'h0003_FFFF_7FFF_7FFF},
    {2'b11, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000},
    {2'b00, 64'hABCD_EF01_2345_6789, 64'h1357_9BDF_2468_ACE0},
    {2'b01, 64'hABCD_EF01_2345_6789, 64'h1357_9BDF_2468_ACE0},
    {2'b10, 64'hABCD_EF01_2345_6789, 64'h1357_9BDF_2468_ACE0}
  };

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    longint ps [4];
    longint pu [4];
    logic [31:0] s;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      ps[i] = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
      pu[i] = longint'({48'd0, a[16*i +: 16]}) * longint'({48'd0, b[16*i +: 16]});
    end
    for (int i = 0; i < 4; i++) begin
      case (op)
        2'b00: r[16*i +: 16] = ps[i][15:0];
        2'b01: r[16*i +: 16] = ps[i][31:16];
        2'b10: r[16*i +: 16] = pu[i][31:16];
        default: ;
      endcase
    end
    if (op == 2'b11) begin
      s = 32'(ps[0] + ps[1]); r[31:0]  = s;
      s = 32'(ps[2] + ps[3]); r[63:32] = s;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  string tag;

  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp;
    exp = model(op, a, b);
    tag = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : (op == 2'b10) ? "R4" : "R5";
    issue(op, a, b);
    check("R7 busy", {63'd0, busy_o}, 64'd1);
    check("R7 early done", {63'd0, done_o}, 64'd0);
    @(negedge clk_i);
    check("R7 done", {63'd0, done_o}, 64'd1);
    check(tag, result_o, exp);
    @(negedge clk_i);
    check("R7 pulse", {63'd0, done_o}, 64'd0);
    check("R8 hold", result_o, exp);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] e1, e2;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 result", result_o, 64'd0);
    check("R1 flags", {62'd0, busy_o, done_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 after release", {result_o[61:0], busy_o, done_o}, 64'd0);

    foreach (VEC[k]) run_one(VEC[k][129:128], VEC[k][127:64], VEC[k][63:0]);

    // R6 all 0x8000 multiply-add
    run_one(2'b11, {4{16'h8000}}, {4{16'h8000}});
    check("R6", result_o, 64'h8000_0000_8000_0000);

    // R9 start while busy ignored
    e1 = model(2'b00, 64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003);
    issue(2'b00, 64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003);
    start_i = 1'b1; op_i = 2'b10; a_i = '1; b_i = '1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R9 done", {63'd0, done_o}, 64'd1);
    check("R9 result", result_o, e1);
    @(negedge clk_i);
    check("R9 no extra busy", {63'd0, busy_o}, 64'd0);
    @(negedge clk_i);
    check("R9 no extra done", {63'd0, done_o}, 64'd0);
    check("R9 result kept", result_o, e1);

    // R10 start in the done cycle
    e1 = model(2'b01, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF);
    e2 = model(2'b11, 64'h0010_0020_0030_0040, 64'hFFFF_0002_0003_0004);
    issue(2'b01, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF);
    @(negedge clk_i);
    check("R10 first done", {63'd0, done_o}, 64'd1);
    check("R10 first result", result_o, e1);
    start_i = 1'b1; op_i = 2'b11; a_i = 64'h0010_0020_0030_0040; b_i = 64'hFFFF_0002_0003_0004;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R10 busy", {62'd0, busy_o, done_o}, 64'd2);
    check("R10 held", result_o, e1);
    @(negedge clk_i);
    check("R10 second done", {63'd0, done_o}, 64'd1);
    check("R10 second result", result_o, e2);

    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule